// File: doc/BRIEF.md
# Non-Busy Home Directory Controller

This block is the home-node coherence engine for a small group of cache lines in a directory-based multiprocessor. Processors send it read or write requests on the request message class. For each line it keeps a directory entry with a state, an owner node and a vector of sharers. It then does one of two things. When the home copy is current, it answers the requester directly. When another node owns the line, it forwards the request to that node. In both cases the directory entry is rewritten in the same clock edge that accepts the request.

The controller has no transient busy state and never sends a negative acknowledgement. A forwarded request is always serviced by its owner. Ownership moves to the new requester at once, and later requests to the same line are accepted on the very next cycle. Conflicts are resolved at the owners, which works because messages toward each node arrive in order. For writes to shared data, the home sends invalidations to the other sharers. It also replies to the writer eagerly, with the number of invalidation acknowledgements the writer still has to collect.

Every message the home sends goes into a first-in first-out queue for its destination node. A single request can queue at most one message per destination. The controller accepts a request only when every destination queue has room.

Top module: `home_dir_ctrl`

## Requirements
- R1: While reset is active, and on the first cycles after it, no message is valid and `req_ready` is high. Every line starts Invalid, with no owner and no sharers.
- R2: A read to an Invalid or Shared line queues a kind 0 (shared data) message to the requester with count 0. The line becomes Shared, and the requester is added to its sharer set.
- R3: A write to an Invalid line queues a kind 1 (exclusive data) message to the requester with count 0. The line becomes Owned by the requester, with an empty sharer set.
- R4: A write to a Shared line queues a kind 5 (invalidate) message to each sharer other than the requester. It also queues a kind 1 message to the requester, whose count is the number of invalidations sent. The line becomes Owned by the requester.
- R5: A read to a line Owned by another node queues a kind 3 (forwarded read) message to the owner and a kind 2 (coherence ack) message to the requester with count 0. The owner is kept and the requester is added as a sharer.
- R6: A write to a line Owned by another node queues a kind 4 (forwarded write) message to the old owner. It queues a kind 5 message to each sharer other than the requester, and a kind 2 message to the requester whose count is the number of those invalidations. Ownership passes to the requester at the accepting edge, so a request to the same line on the next cycle is accepted and sent to the new owner.
- R7: A read from the current owner queues a kind 2 message with count 0 and leaves the line unchanged. A write from the owner invalidates the other sharers, with a kind 5 message to each. It then answers with a kind 1 message carrying their number and leaves the sharer set empty.
- R8: Messages toward any one node leave in the order their requests were accepted. A message that is offered but not taken holds valid with all of its fields stable.
- R9: No negative acknowledgement or retry exists: every accepted request queues a reply or ack toward its requester, visible the next cycle. `req_ready` is low only while some destination queue is full.
- Message fields of each destination: `msg_peer` is always the requesting node and `msg_addr` is the line index. `msg_cnt` carries the acknowledgement count on kinds 1 and 2 and is 0 on all other kinds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_src | input | 3 | Requesting node |
| req_write | input | 1 | 1 = write (exclusive) request, 0 = read |
| req_addr | input | 4 | Line index |
| msg_valid | output | 8 | Per destination node: message offered |
| msg_ready | input | 8 | Per destination node: network takes the message |
| msg_kind | output | 24 | 3 bits per node at bits [3d+2:3d]: 0 shared data, 1 exclusive data, 2 coherence ack, 3 forwarded read, 4 forwarded write, 5 invalidate |
| msg_peer | output | 24 | 3 bits per node: requesting node |
| msg_addr | output | 32 | 4 bits per node: line index |
| msg_cnt | output | 24 | 3 bits per node: acknowledgements the requester must collect |

## Verification
The hardest situation to reach is a chain of conflicting requests to one line on back-to-back cycles. In such a chain the ownership is taken over again before the earlier forwards have left their queues, while the network stalls some destinations. Directed sequences build that chain on one line with every queue open. The random phase then confines addresses to four lines, draws requesters from all eight nodes and holds per-destination ready low a quarter of the time. Queues therefore fill, `req_ready` drops, and forwards and acks to the same node pile up behind one another.

// File: rtl/home_dir_pkg.sv
package home_dir_pkg;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_OWN = 2'd2
  } line_st_e;

  typedef enum logic [2:0] {
    MK_DATA_SH = 3'd0,
    MK_DATA_EX = 3'd1,
    MK_CACK    = 3'd2,
    MK_FWD_RD  = 3'd3,
    MK_FWD_WR  = 3'd4,
    MK_INV     = 3'd5
  } msg_kind_e;

endpackage

// File: rtl/hd_rst_sync.sv
module hd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/hd_decode.sv
module hd_decode
  import home_dir_pkg::*;
#(
  parameter int NODES  = 8,
  parameter int NODE_W = 3,
  parameter int CNT_W  = 3
) (
  input  line_st_e                 cur_st,
  input  logic [NODE_W-1:0]        cur_own,
  input  logic [NODES-1:0]         cur_shr,
  input  logic [NODE_W-1:0]        src,
  input  logic                     wr,
  output line_st_e                 nxt_st,
  output logic [NODE_W-1:0]        nxt_own,
  output logic [NODES-1:0]         nxt_shr,
  output logic [NODES-1:0]         push,
  output logic [NODES-1:0][2:0]    dkind,
  output logic [CNT_W-1:0]         ack_cnt
);
  logic [NODES-1:0] src_bit, own_bit, others, inv_mask;
  logic             fwd;
  msg_kind_e        rep_kind, fwd_kind;

  assign src_bit = NODES'(1) << src;
  assign own_bit = NODES'(1) << cur_own;
  assign others  = cur_shr & ~src_bit;

  always_comb begin
    nxt_st   = cur_st;
    nxt_own  = cur_own;
    nxt_shr  = cur_shr;
    inv_mask = '0;
    fwd      = 1'b0;
    fwd_kind = MK_FWD_RD;
    rep_kind = MK_DATA_SH;
    case (cur_st)
      LN_SHR: begin
        if (wr) begin
          inv_mask = others;
          rep_kind = MK_DATA_EX;
          nxt_st   = LN_OWN;
          nxt_own  = src;
          nxt_shr  = '0;
        end else begin
          nxt_shr  = cur_shr | src_bit;
        end
      end
      LN_OWN: begin
        if (src == cur_own) begin
          if (wr) begin
            inv_mask = others;
            rep_kind = MK_DATA_EX;
            nxt_shr  = '0;
          end else begin
            rep_kind = MK_CACK;
          end
        end else begin
          fwd      = 1'b1;
          rep_kind = MK_CACK;
          if (wr) begin
            fwd_kind = MK_FWD_WR;
            inv_mask = others & ~own_bit;
            nxt_own  = src;
            nxt_shr  = '0;
          end else begin
            nxt_shr  = cur_shr | src_bit;
          end
        end
      end
      default: begin
        if (wr) begin
          rep_kind = MK_DATA_EX;
          nxt_st   = LN_OWN;
          nxt_own  = src;
          nxt_shr  = '0;
        end else begin
          nxt_st   = LN_SHR;
          nxt_shr  = src_bit;
        end
      end
    endcase
  end

  always_comb begin
    ack_cnt = '0;
    for (int i = 0; i < NODES; i++) ack_cnt = ack_cnt + CNT_W'(inv_mask[i]);
  end

  assign push = inv_mask | src_bit | (fwd ? own_bit : '0);

  always_comb begin
    for (int d = 0; d < NODES; d++) begin
      if (NODE_W'(d) == src)                dkind[d] = rep_kind;
      else if (fwd && NODE_W'(d) == cur_own) dkind[d] = fwd_kind;
      else                                  dkind[d] = MK_INV;
    end
  end
endmodule

// File: rtl/hd_fifo.sv
module hd_fifo #(
  parameter int W     = 13,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         valid,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q, wp_d, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_pop;

  assign do_pop = pop && (cnt_q != '0);

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_pop) rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (!push && do_pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign valid = (cnt_q != '0);
  assign full  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
  import home_dir_pkg::*;
#(
  parameter int NODES      = 8,
  parameter int ADDR_W     = 4,
  parameter int FIFO_DEPTH = 4,
  localparam int NODE_W    = $clog2(NODES),
  localparam int CNT_W     = $clog2(NODES),
  localparam int LINES     = 1 << ADDR_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [NODE_W-1:0]         req_src,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  output logic [NODES-1:0]          msg_valid,
  input  logic [NODES-1:0]          msg_ready,
  output logic [3*NODES-1:0]        msg_kind,
  output logic [NODE_W*NODES-1:0]   msg_peer,
  output logic [ADDR_W*NODES-1:0]   msg_addr,
  output logic [CNT_W*NODES-1:0]    msg_cnt
);
  localparam int EW = 3 + NODE_W + ADDR_W + CNT_W;

  logic                   srst_n;
  line_st_e               dir_st  [LINES];
  logic [NODE_W-1:0]      dir_own [LINES];
  logic [NODES-1:0]       dir_shr [LINES];

  line_st_e               nx_st;
  logic [NODE_W-1:0]      nx_own;
  logic [NODES-1:0]       nx_shr;
  logic [NODES-1:0]       push;
  logic [NODES-1:0][2:0]  dkind;
  logic [CNT_W-1:0]       ack_cnt;
  logic [NODES-1:0]       q_full;
  logic                   fire;

  hd_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  hd_decode #(.NODES(NODES), .NODE_W(NODE_W), .CNT_W(CNT_W)) u_dec (
    .cur_st  (dir_st[req_addr]),
    .cur_own (dir_own[req_addr]),
    .cur_shr (dir_shr[req_addr]),
    .src     (req_src),
    .wr      (req_write),
    .nxt_st  (nx_st),
    .nxt_own (nx_own),
    .nxt_shr (nx_shr),
    .push    (push),
    .dkind   (dkind),
    .ack_cnt (ack_cnt)
  );

  assign req_ready = ~|q_full;
  assign fire      = req_valid && req_ready;

  // Directory commits at the accepting edge: no transient state.
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      for (int i = 0; i < LINES; i++) begin
        dir_st[i]  <= LN_INV;
        dir_own[i] <= '0;
        dir_shr[i] <= '0;
      end
    end else if (fire) begin
      dir_st[req_addr]  <= nx_st;
      dir_own[req_addr] <= nx_own;
      dir_shr[req_addr] <= nx_shr;
    end
  end

  for (genvar d = 0; d < NODES; d++) begin : g_dest
    logic [EW-1:0]    din, head;
    logic [CNT_W-1:0] cnt_fld;

    assign cnt_fld = (req_src == NODE_W'(d)) ? ack_cnt : '0;
    assign din     = {dkind[d], req_src, req_addr, cnt_fld};

    hd_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_q (
      .clk   (clk),
      .rst_n (srst_n),
      .push  (fire && push[d]),
      .din   (din),
      .pop   (msg_ready[d]),
      .dout  (head),
      .valid (msg_valid[d]),
      .full  (q_full[d])
    );

    assign msg_kind[3*d +: 3]           = head[EW-1 -: 3];
    assign msg_peer[NODE_W*d +: NODE_W] = head[ADDR_W+CNT_W +: NODE_W];
    assign msg_addr[ADDR_W*d +: ADDR_W] = head[CNT_W +: ADDR_W];
    assign msg_cnt[CNT_W*d +: CNT_W]    = head[0 +: CNT_W];
  end
endmodule

// File: rtl/home_dir_chk.sv
module home_dir_chk
  import home_dir_pkg::*;
#(
  parameter int NODES  = 8,
  parameter int ADDR_W = 4,
  localparam int NODE_W = $clog2(NODES),
  localparam int CNT_W  = $clog2(NODES),
  localparam int LINES  = 1 << ADDR_W
) (
  input logic                    clk,
  input logic                    srst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic [NODE_W-1:0]       req_src,
  input logic                    req_write,
  input logic [ADDR_W-1:0]       req_addr,
  input logic [NODES-1:0]        msg_valid,
  input logic [NODES-1:0]        msg_ready,
  input logic [3*NODES-1:0]      msg_kind,
  input logic [NODE_W*NODES-1:0] msg_peer,
  input logic [ADDR_W*NODES-1:0] msg_addr,
  input logic [CNT_W*NODES-1:0]  msg_cnt,
  input line_st_e                dir_st  [LINES],
  input logic [NODE_W-1:0]       dir_own [LINES]
);
  assert_idle_in_reset_R1: assert property (@(posedge clk)
    !srst_n |-> (msg_valid == '0));

  assert_read_shares_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && req_ready && !req_write) |=> (dir_st[$past(req_addr)] != LN_INV));

  assert_write_commit_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && req_ready && req_write) |=>
      (dir_st[$past(req_addr)] == LN_OWN) && (dir_own[$past(req_addr)] == $past(req_src)));

  assert_reply_queued_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && req_ready) |=> msg_valid[$past(req_src)]);

  for (genvar d = 0; d < NODES; d++) begin : g_hold
    assert_hold_R8: assert property (@(posedge clk) disable iff (!srst_n)
      (msg_valid[d] && !msg_ready[d]) |=>
        (msg_valid[d] && $stable(msg_kind[3*d +: 3]) &&
         $stable(msg_peer[NODE_W*d +: NODE_W]) &&
         $stable(msg_addr[ADDR_W*d +: ADDR_W]) &&
         $stable(msg_cnt[CNT_W*d +: CNT_W])));
  end
endmodule

bind home_dir_ctrl home_dir_chk #(.NODES(NODES), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_src   (req_src),
  .req_write (req_write),
  .req_addr  (req_addr),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_kind  (msg_kind),
  .msg_peer  (msg_peer),
  .msg_addr  (msg_addr),
  .msg_cnt   (msg_cnt),
  .dir_st    (dir_st),
  .dir_own   (dir_own)
);

// File: tb/sim_home_dir_ctrl.sv
module sim_home_dir_ctrl;
  localparam int N     = 8;
  localparam int DEPTH = 4;

  logic          clk, rst_n;
  logic          req_valid, req_ready, req_write;
  logic [2:0]    req_src;
  logic [3:0]    req_addr;
  logic [7:0]    msg_valid, msg_ready;
  logic [23:0]   msg_kind, msg_peer, msg_cnt;
  logic [31:0]   msg_addr;

  int tests, fails;
  bit done;

  int         mst  [16];
  int         mown [16];
  logic [7:0] mshr [16];
  logic [12:0] eq [N][$];
  string       et [N][$];

  home_dir_ctrl #(.NODES(N), .ADDR_W(4), .FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_write(req_write), .req_addr(req_addr),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
    .msg_peer(msg_peer), .msg_addr(msg_addr), .msg_cnt(msg_cnt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(bit ok, string tag, string what, int got, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic put(int d, int kind, int s, int a, int cnt, string tag);
    eq[d].push_back({3'(kind), 3'(s), 4'(a), 3'(cnt)});
    et[d].push_back(tag);
  endtask

  task automatic inv_all(logic [7:0] victims, int s, int a, string tag, output int n);
    n = 0;
    for (int i = 0; i < N; i++) if (victims[i]) begin put(i, 5, s, a, 0, tag); n++; end
  endtask

  // Reference behaviour taken from the requirements.
  task automatic model(int s, bit w, int a);
    logic [7:0] sb, ob;
    int o, n;
    sb = 8'(1 << s);
    o  = mown[a];
    ob = 8'(1 << o);
    if (mst[a] == 0) begin
      if (w) begin put(s, 1, s, a, 0, "R3"); mst[a] = 2; mown[a] = s; mshr[a] = 0; end
      else   begin put(s, 0, s, a, 0, "R2"); mst[a] = 1; mshr[a] = sb; end
    end else if (mst[a] == 1) begin
      if (w) begin
        inv_all(mshr[a] & ~sb, s, a, "R4", n);
        put(s, 1, s, a, n, "R4"); mst[a] = 2; mown[a] = s; mshr[a] = 0;
      end else begin
        put(s, 0, s, a, 0, "R2"); mshr[a] = mshr[a] | sb;
      end
    end else if (s == o) begin
      if (w) begin
        inv_all(mshr[a] & ~sb, s, a, "R7", n);
        put(s, 1, s, a, n, "R7"); mshr[a] = 0;
      end else put(s, 2, s, a, 0, "R7");
    end else if (w) begin
      inv_all(mshr[a] & ~sb & ~ob, s, a, "R6", n);
      put(o, 4, s, a, 0, "R6");
      put(s, 2, s, a, n, "R6");
      mown[a] = s; mshr[a] = 0;
    end else begin
      put(o, 3, s, a, 0, "R5");
      put(s, 2, s, a, 0, "R5");
      mshr[a] = mshr[a] | sb;
    end
  endtask

  task automatic cyc(bit rv, int s, bit w, int a, logic [7:0] rdy);
    bit exp_rdy;
    @(negedge clk);
    req_valid = rv; req_src = 3'(s); req_write = w; req_addr = 4'(a); msg_ready = rdy;
    #1;
    exp_rdy = 1'b1;
    for (int d = 0; d < N; d++) if (eq[d].size() >= DEPTH) exp_rdy = 1'b0;
    chk(req_ready == exp_rdy, "R9", "req_ready", int'(req_ready), int'(exp_rdy));
    for (int d = 0; d < N; d++) begin
      chk(msg_valid[d] == (eq[d].size() != 0), "R8", $sformatf("msg_valid[%0d]", d),
          int'(msg_valid[d]), int'(eq[d].size() != 0));
      if (msg_valid[d] && msg_ready[d] && eq[d].size() != 0) begin
        logic [12:0] got, exp;
        string tg;
        got = {msg_kind[3*d +: 3], msg_peer[3*d +: 3], msg_addr[4*d +: 4], msg_cnt[3*d +: 3]};
        exp = eq[d].pop_front();
        tg  = et[d].pop_front();
        chk(got == exp, {tg, "/R8"}, $sformatf("dest %0d message", d), int'(got), int'(exp));
      end
    end
    if (rv && req_ready) model(s, w, a);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    tests = 0; fails = 0; done = 1'b0;
    for (int i = 0; i < 16; i++) begin mst[i] = 0; mown[i] = 0; mshr[i] = 0; end
    rst_n = 1'b0; req_valid = 1'b0; req_src = '0; req_write = 1'b0; req_addr = '0;
    msg_ready = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(msg_valid == 8'h00, "R1", "msg_valid in reset", int'(msg_valid), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(msg_valid == 8'h00, "R1", "msg_valid after reset", int'(msg_valid), 0);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);

    // Directed: one line walked through every transition, back to back.
    cyc(1, 2, 0, 1, 8'hFF);  // R2 read Invalid
    cyc(1, 5, 0, 1, 8'hFF);  // R2 second sharer
    cyc(1, 2, 1, 1, 8'hFF);  // R4 write to Shared, invalidates node 5
    cyc(1, 3, 0, 1, 8'hFF);  // R5 forwarded read to owner 2
    cyc(1, 4, 1, 1, 8'hFF);  // R6 forwarded write, invalidates 3
    cyc(1, 6, 1, 1, 8'hFF);  // R6 next cycle goes to new owner 4
    cyc(1, 6, 0, 1, 8'hFF);  // R7 owner read
    cyc(1, 7, 0, 1, 8'hFF);  // R5
    cyc(1, 6, 1, 1, 8'hFF);  // R7 owner write invalidates 7
    cyc(1, 0, 1, 9, 8'hFF);  // R3 write Invalid
    repeat (4) cyc(0, 0, 0, 0, 8'hFF);

    // Directed: stalled network fills one queue, request held off (R9, R8).
    for (int k = 0; k < 6; k++) cyc(1, 1, 0, 12, 8'h00);
    repeat (3) cyc(0, 0, 0, 0, 8'h00);
    repeat (6) cyc(0, 0, 0, 0, 8'hFF);

    // Random conflicts on four lines with a stalling network.
    for (int k = 0; k < 5000; k++) begin
      logic [7:0] rdy;
      rdy = '0;
      for (int d = 0; d < N; d++) rdy[d] = ($urandom % 4) != 0;
      cyc(($urandom % 10) < 6, int'($urandom % 8), bit'($urandom % 2),
          int'($urandom % 4), rdy);
    end
    repeat (12) cyc(0, 0, 0, 0, 8'hFF);
    for (int d = 0; d < N; d++)
      chk(eq[d].size() == 0, "R8", $sformatf("drained dest %0d", d), eq[d].size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule